// File: doc/BRIEF.md
# Timebase and Interrupt Source Controller

This block turns the CPU clock into three slow periodic ticks and collects them, together with two timer overflow pulses and an external request pin, into one maskable interrupt request and one non-maskable request for the processor. A free-running prescaler produces a tick every 1024, 8192 and 65536 clock cycles. Every source has a sticky pending flag and an enable bit. The maskable request is raised while any flag that is both pending and enabled is set.

Software reaches the block through a small register port. It writes the enable mask, reads the pending flags, and acknowledges a flag by writing a one to its bit. One control bit sends timer A overflows to the non-maskable line, so that sample playback can be paced exactly. The external request is a falling edge on a pin that is shared with a general-purpose port bit. The pin is synchronised inside the block.

Top module: `intsrc_ctrl`

## Requirements
- R1: After reset the enable mask, the pending flags and the routing bit are zero, and `irq` and `nmi` are low.
- R2: Source bit 2 (clock/1024 tick) sets on edge 1025 after reset release and then on every 1024th edge after it. Two sets of this bit are exactly 1024 cycles apart.
- R3: Source bit 3 (clock/8192) and source bit 4 (clock/65536) set on the edges numbered 8193 + k·8192 and 65537 + k·65536 after reset release.
- R4: A one-cycle pulse on `tmra_ovf` (when it is not routed) sets bit 0. A one-cycle pulse on `tmrb_ovf` sets bit 1. In both cases the flag is readable in the cycle after the pulse.
- R5: A falling edge on `ext_pin` sets bit 5, and the flag becomes readable after the third rising clock edge that samples the low level. A rising edge on the pin sets nothing.
- R6: A flag sets whatever its enable bit holds. `irq` is high exactly while some bit is set in both the pending flags and the enable mask.
- R7: Writing to address 1 clears every pending bit for which the written data holds a one. Bits written as zero are unchanged. A source pulse in the same cycle as the clear of its bit wins, and the bit stays set.
- R8: When the routing bit is one, each `tmra_ovf` pulse gives a one-cycle `nmi` pulse in the following cycle and leaves bit 0 clear. When the routing bit is zero, `nmi` stays low.
- R9: The registers are address 0, the enable mask in bits 5:0; address 1, the pending flags in bits 5:0; address 2, the routing bit in bit 0; and address 3, which reads zero. Unused read bits are zero. `reg_rdata` follows `reg_addr` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmra_ovf | input | 1 | Timer A overflow pulse, one cycle wide |
| tmrb_ovf | input | 1 | Timer B overflow pulse, one cycle wide |
| ext_pin | input | 1 | External request pin, asynchronous, active on falling edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Maskable interrupt request, level |
| nmi | output | 1 | Non-maskable interrupt request, one-cycle pulse |

## Verification
The assertions rely on a few conditions at the inputs:
- reset is applied once at start-up;
- every timer overflow is a single-cycle pulse;
- the register port presents one write per strobe cycle.

The external pin is the one input allowed to change at any time. The stimulus meets these conditions by driving every input one nanosecond after a rising edge. Timer pulses are only issued after a low cycle, and writes use random addresses and data, including acknowledges that land in the same cycle as a new source pulse.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int NSRC = 6;
  localparam int NTAP = 3;

  localparam int SRC_TMRA = 0;
  localparam int SRC_TMRB = 1;
  localparam int SRC_TB0  = 2;
  localparam int SRC_EXT  = 5;

  typedef enum logic [1:0] {
    RA_ENABLE = 2'd0,
    RA_PEND   = 2'd1,
    RA_CTRL   = 2'd2,
    RA_RSVD   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tbase_prescaler.sv
`timescale 1ns/1ps
module tbase_prescaler
  import intc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TAP_LO  = 10,
  parameter int TAP_MID = 13,
  parameter int TAP_HI  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NTAP-1:0] tick
);
  function automatic int tap_of(input int g);
    case (g)
      0:       return TAP_LO;
      1:       return TAP_MID;
      default: return TAP_HI;
    endcase
  endfunction

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  // one registered pulse per tap, raised in the cycle after the low bits roll over
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int TW = tap_of(g);
    logic t_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) t_q <= 1'b0;
      else        t_q <= (cnt[TW-1:0] == {TW{1'b1}});
    end

    assign tick[g] = t_q;

    // R2 / R3: a tick lasts one cycle
    a_r2_tick_single : assert property (@(posedge clk) disable iff (!rst_n)
      t_q |=> !t_q);

    // R3: a tick only appears just after the tap bits wrapped to zero
    a_r3_tick_aligned : assert property (@(posedge clk) disable iff (!rst_n)
      t_q |-> (cnt[TW-1:0] == {TW{1'b0}}));
  end
endmodule

// File: rtl/ext_fall_detect.sv
`timescale 1ns/1ps
module ext_fall_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  // stages [SYNC_STAGES-1:0] synchronise, the top stage keeps the previous level
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[SYNC_STAGES-1:0], pin};
  end

  assign fall = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];

  // R5: one detection per edge
  a_r5_fall_single : assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/irq_regbank.sv
`timescale 1ns/1ps
module irq_regbank
  import intc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   set_vec,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              route_nmi
);
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] clr;
  logic            wr_en_reg;
  logic            wr_pend;
  logic            wr_ctrl;

  assign wr_en_reg = wr && (addr == ADDR_W'(RA_ENABLE));
  assign wr_pend   = wr && (addr == ADDR_W'(RA_PEND));
  assign wr_ctrl   = wr && (addr == ADDR_W'(RA_CTRL));
  assign clr       = wr_pend ? wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      pend_q    <= '0;
      route_nmi <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr) | set_vec;
      if (wr_en_reg) en_q      <= wdata[NSRC-1:0];
      if (wr_ctrl)   route_nmi <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(RA_ENABLE): rdata[NSRC-1:0] = en_q;
      ADDR_W'(RA_PEND):   rdata[NSRC-1:0] = pend_q;
      ADDR_W'(RA_CTRL):   rdata[0]        = route_nmi;
      default:            rdata           = '0;
    endcase
  end

  assign irq = |(pend_q & en_q);

  if (DATA_W > NSRC) begin : g_spare
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:NSRC];
  end

  // R4: a source pulse always leaves its flag set
  a_r4_set_sticks : assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // R7: an acknowledged bit without a fresh pulse is gone next cycle
  a_r7_clear_takes : assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend_q & $past(clr & ~set_vec)) == '0));

  // R6: nothing enabled means no request
  a_r6_masked_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

// File: rtl/intsrc_ctrl.sv
`timescale 1ns/1ps
module intsrc_ctrl
  import intc_pkg::*;
#(
  parameter int PRESC_W     = 16,
  parameter int TAP_LO      = 10,
  parameter int TAP_MID     = 13,
  parameter int TAP_HI      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmra_ovf,
  input  logic              tmrb_ovf,
  input  logic              ext_pin,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              nmi
);
  logic [NTAP-1:0] tick;
  logic            ext_fall;
  logic            route;
  logic [NSRC-1:0] set_vec;
  logic            nmi_q;

  tbase_prescaler #(
    .CNT_W  (PRESC_W),
    .TAP_LO (TAP_LO),
    .TAP_MID(TAP_MID),
    .TAP_HI (TAP_HI)
  ) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  ext_fall_detect #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ext (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_pin),
    .fall (ext_fall)
  );

  always_comb begin
    set_vec                           = '0;
    set_vec[SRC_TMRA]                 = tmra_ovf & ~route;
    set_vec[SRC_TMRB]                 = tmrb_ovf;
    set_vec[SRC_TB0 +: NTAP]          = tick;
    set_vec[SRC_EXT]                  = ext_fall;
  end

  irq_regbank #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .irq      (irq),
    .route_nmi(route)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_q <= 1'b0;
    else        nmi_q <= tmra_ovf & route;
  end

  assign nmi = nmi_q;

  // R8: a non-maskable pulse follows a timer A overflow
  a_r8_nmi_from_timer : assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> $past(tmra_ovf));

  // R8: a non-maskable pulse only appears while routing was selected
  a_r8_nmi_needs_route : assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> $past(route));
endmodule

// File: tb/test_intsrc_ctrl.sv
`timescale 1ns/1ps
module test_intsrc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       tmra = 1'b0, tmrb = 1'b0, ext = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, nmi;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intsrc_ctrl i_intsrc_ctrl (
    .clk(clk), .rst_n(rst_n), .tmra_ovf(tmra), .tmrb_ovf(tmrb), .ext_pin(ext),
    .reg_wr(wr_en), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .irq(irq), .nmi(nmi)
  );

  // ---------------- reference model built from the requirements
  int         ecnt;
  logic [5:0] m_en, m_pend;
  logic       m_route, m_nmi;
  logic       p1, p2, p3;

  function automatic logic [5:0] exp_set(input int e, input logic ta, input logic tb,
                                         input logic rt, input logic h2, input logic h3);
    logic [5:0] s;
    s    = '0;
    s[0] = ta & ~rt;
    s[1] = tb;
    s[2] = (e > 1) && ((e - 1) % 1024 == 0);
    s[3] = (e > 1) && ((e - 1) % 8192 == 0);
    s[4] = (e > 1) && ((e - 1) % 65536 == 0);
    s[5] = h3 & ~h2;
    return s;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {2'b00, m_en};
      2'd1:    return {2'b00, m_pend};
      2'd2:    return {7'd0, m_route};
      default: return 8'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic [5:0] s, c;
    if (!rst_n) begin
      ecnt <= 0; m_en <= '0; m_pend <= '0; m_route <= 1'b0; m_nmi <= 1'b0;
      p1 <= 1'b1; p2 <= 1'b1; p3 <= 1'b1;
    end else begin
      s = exp_set(ecnt + 1, tmra, tmrb, m_route, p2, p3);
      c = (wr_en && addr == 2'd1) ? wdata[5:0] : 6'd0;
      m_pend <= (m_pend & ~c) | s;
      if (wr_en && addr == 2'd0) m_en <= wdata[5:0];
      if (wr_en && addr == 2'd2) m_route <= wdata[0];
      m_nmi <= tmra & m_route;
      p1 <= ext; p2 <= p1; p3 <= p2;
      ecnt <= ecnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%h expected=%h at edge %0d", req, act, exp, ecnt);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && ecnt > 0 && !done) begin
      chk(irq == |(m_pend & m_en), "R6 irq", {7'd0, irq}, {7'd0, |(m_pend & m_en)});
      chk(nmi == m_nmi, "R8 nmi", {7'd0, nmi}, {7'd0, m_nmi});
      chk(rdata == exp_rd(addr), (addr == 2'd1) ? "R3 pending" : "R9 regs",
          rdata, exp_rd(addr));
    end
  end

  // ---------------- stimulus helpers
  task automatic edge_drive();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    edge_drive(); wr_en = 1'b1; addr = a; wdata = d;
    edge_drive(); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] mask, input logic [7:0] exp,
                        input string req);
    edge_drive(); addr = a;
    @(negedge clk);
    chk((rdata & mask) == exp, req, rdata & mask, exp);
  endtask

  // ---------------- watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  // ---------------- main sequence
  initial begin : main
    int t_first;
    int t_second;
    process::self().srandom(32'h5eed_1234);
    #1 rst_n = 1'b0;

    // R1: reset state on every address
    for (int a = 0; a < 4; a++) begin
      edge_drive(); addr = 2'(a);
      @(negedge clk);
      chk(rdata == 8'd0, "R1 reset regs", rdata, 8'd0);
    end
    chk(irq == 1'b0 && nmi == 1'b0, "R1 reset outputs", {6'd0, irq, nmi}, 8'd0);
    edge_drive(); rst_n = 1'b1;

    // R4 + R6: disabled timer A sets its flag but not irq
    edge_drive(); tmra = 1'b1; addr = 2'd1;
    edge_drive(); tmra = 1'b0;
    @(negedge clk);
    chk((rdata & 8'h03) == 8'h01, "R4 timer A flag", rdata & 8'h03, 8'h01);
    chk(irq == 1'b0, "R6 disabled no irq", {7'd0, irq}, 8'd0);
    wr(2'd0, 8'h01);
    @(negedge clk);
    chk(irq == 1'b1, "R6 enabled irq", {7'd0, irq}, 8'd1);

    // R4: timer B
    edge_drive(); tmrb = 1'b1;
    edge_drive(); tmrb = 1'b0;
    rd_chk(2'd1, 8'h02, 8'h02, "R4 timer B flag");

    // R7: write-zero keeps, write-one clears
    wr(2'd1, 8'h00);
    rd_chk(2'd1, 8'h03, 8'h03, "R7 zero keeps");
    wr(2'd1, 8'h03);
    rd_chk(2'd1, 8'h03, 8'h00, "R7 one clears");
    chk(irq == 1'b0, "R7 irq after ack", {7'd0, irq}, 8'd0);

    // R8: routing to nmi
    wr(2'd2, 8'h01);
    edge_drive(); tmra = 1'b1; addr = 2'd1;
    @(negedge clk);
    chk(nmi == 1'b0, "R8 nmi not early", {7'd0, nmi}, 8'd0);
    edge_drive(); tmra = 1'b0;
    @(negedge clk);
    chk(nmi == 1'b1, "R8 nmi pulse", {7'd0, nmi}, 8'd1);
    chk((rdata & 8'h01) == 8'h00, "R8 flag stays clear", rdata & 8'h01, 8'h00);
    @(negedge clk);
    chk(nmi == 1'b0, "R8 nmi one cycle", {7'd0, nmi}, 8'd0);
    wr(2'd2, 8'h00);

    // R5: falling edge, three edges of latency
    edge_drive(); ext = 1'b0; addr = 2'd1;
    @(negedge clk);
    @(negedge clk);
    chk((rdata & 8'h20) == 8'h00, "R5 not after 1", rdata & 8'h20, 8'h00);
    @(negedge clk);
    chk((rdata & 8'h20) == 8'h00, "R5 not after 2", rdata & 8'h20, 8'h00);
    @(negedge clk);
    chk((rdata & 8'h20) == 8'h20, "R5 set after 3", rdata & 8'h20, 8'h20);
    wr(2'd1, 8'h20);
    edge_drive(); ext = 1'b1;
    repeat (6) edge_drive();
    rd_chk(2'd1, 8'h20, 8'h00, "R5 rising ignored");

    // R7: set beats clear in the same cycle
    edge_drive(); wr_en = 1'b1; addr = 2'd1; wdata = 8'h02; tmrb = 1'b1;
    edge_drive(); wr_en = 1'b0; tmrb = 1'b0;
    rd_chk(2'd1, 8'h02, 8'h02, "R7 set wins");
    wr(2'd1, 8'h02);
    rd_chk(2'd1, 8'h02, 8'h00, "R7 cleared after");

    // R9: map and unused bits
    wr(2'd0, 8'hFF);
    rd_chk(2'd0, 8'hFF, 8'h3F, "R9 enable width");
    rd_chk(2'd3, 8'hFF, 8'h00, "R9 spare address");
    wr(2'd2, 8'hFE);
    rd_chk(2'd2, 8'hFF, 8'h00, "R9 route bit only");
    wr(2'd0, 8'h00);

    // R2: tick spacing
    wr(2'd1, 8'h04);
    addr = 2'd1;
    do @(negedge clk); while (rdata[2] == 1'b0);
    t_first = ecnt;
    wr(2'd1, 8'h04);
    addr = 2'd1;
    do @(negedge clk); while (rdata[2] == 1'b0);
    t_second = ecnt;
    chk((t_second - t_first) == 1024, "R2 tick spacing", 8'(t_second - t_first), 8'(1024));
    chk((t_first - 1) % 1024 == 0, "R2 tick phase", 8'((t_first - 1) % 1024), 8'd0);

    // R3: clock/8192 tick arrives before clock/65536
    wr(2'd1, 8'h18);
    while (ecnt < 8200) @(negedge clk);
    rd_chk(2'd1, 8'h18, 8'h08, "R3 tick 8192");

    // random mix checked every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      edge_drive();
      tmra  = !tmra && ($urandom_range(15) == 0);
      tmrb  = !tmrb && ($urandom_range(15) == 0);
      if ($urandom_range(31) == 0) ext = ~ext;
      wr_en = ($urandom_range(7) == 0);
      addr  = 2'($urandom_range(3));
      wdata = 8'($urandom);
    end
    edge_drive(); tmra = 1'b0; tmrb = 1'b0; wr_en = 1'b0; ext = 1'b1;

    // R3: slowest tick
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h10);
    while (ecnt < 65600) @(negedge clk);
    rd_chk(2'd1, 8'h10, 8'h10, "R3 tick 65536");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule